// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer

This block turns one bus request from an 8-bit processor core into a machine cycle on the external bus. The core gives a cycle kind (memory read, memory write, I/O read or I/O write), a 16-bit address and, for writes, a data byte. The sequencer then steps through its T-states, one clock per state: T1, T2, any wait states, and T3. During these states it drives the address, the memory or I/O space strobe, the read or write strobe and the data output enable. At the end it returns the captured read byte with a one-clock done pulse.

Memory cycles are stretched by one wait state (Tw) for every clock in which the active-low wait input is seen low at the end of T2 or of a Tw. I/O cycles always get one built-in wait state (Ta) after T2, so a slow port has time to decode its address. The wait input is first looked at at the end of that state, and any further Tw states follow in the same way as for memory cycles. For writes, the write strobe is released at the start of T3 while the data stays driven, so a port can latch the byte on the strobe's rising edge.

The core presents a request with `req_valid` and may only have it taken while `req_ready` is high. `req_ready` stays low from acceptance through the done clock.

Top module: `bcyc_seq`

## Requirements
- R1: After reset, all four bus strobes are high, `dout_oe` is low, `done` is low and `req_ready` is high.
- R2: A memory cycle with `wait_n` held high has its space strobe low for exactly 3 clocks (T1, T2, T3). `done` is high in the 4th clock after the accepting edge.
- R3: In a memory cycle, each clock at the end of which `wait_n` is low during T2 or a Tw adds exactly one clock to the cycle.
- R4: An I/O cycle with `wait_n` held high lasts 4 strobe clocks (T1, T2, Ta, T3). `wait_n` low during the T2 clock of an I/O cycle has no effect.
- R5: In an I/O cycle, each clock at the end of which `wait_n` is low during Ta or a Tw adds exactly one clock to the cycle.
- R6: `req_kind` bit 1 selects I/O (1) or memory (0), and bit 0 selects write (1) or read (0). Only `iorq_n` or only `mreq_n` is driven low, matching bit 1. `addr` equals the request address and stays stable in every strobe clock.
- R7: In a read cycle, `rd_n` is low in every strobe clock and `wr_n` stays high. `rdata` in the done clock equals the `din` value present in the clock just before T3.
- R8: In a write cycle, `dout_oe` is high and `dout` equals the request data in every strobe clock. `wr_n` is low from T2 through the last wait state, which is (strobe clocks − 2) clocks, and high in T3 while `dout_oe` is still high.
- R9: `rd_n` and `wr_n` are never low together, and `mreq_n` and `iorq_n` are never low together.
- R10: `done` is high for exactly one clock. `req_ready` is low from the accepting edge through the done clock and high in the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 2 | Bit 1: I/O space, bit 0: write |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer can take a request |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Byte captured by a read cycle |
| wait_n | input | 1 | Active-low wait request |
| din | input | 8 | Data bus input |
| addr | output | 16 | Address bus |
| dout | output | 8 | Data bus output value |
| dout_oe | output | 1 | Data bus output enable |
| mreq_n | output | 1 | Memory space strobe, active low |
| iorq_n | output | 1 | I/O space strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Clocks are counted from the edge that accepts a request. In clock k=1 the block is in T1. `done` is due in clock 4+n for a memory cycle and in clock 5+n for an I/O cycle with n requested waits. The read byte is captured from `din` in clock 2+n (memory) or 3+n (I/O). The bench drives `wait_n` and `din` on falling edges, as a function of k, and holds the expected byte on `din` only in the capture clock. It samples the outputs one time step later in the same half period, and compares the clock in which `done` appears and the number of clocks each strobe was low against those formulas.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

  // T-state of the current machine cycle; one clock per state
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TA   = 3'd3,  // automatic I/O wait state
    TS_TW   = 3'd4,  // requested wait state
    TS_T3   = 3'd5
  } tstate_e;

  // Request kind: bit 1 selects I/O space, bit 0 selects a write
  typedef struct packed {
    logic io;
    logic wr;
  } ckind_s;

endpackage

// File: rtl/bcyc_rst_sync.sv
module bcyc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/bcyc_tstate_fsm.sv
module bcyc_tstate_fsm
  import bcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    is_io,
  input  logic    wait_n,
  output tstate_e state_o,
  output logic    cap_o,
  output logic    done_o
);

  tstate_e st_q, st_d;
  logic    done_q, done_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_IDLE: if (start) st_d = TS_T1;
      TS_T1:   st_d = TS_T2;
      TS_T2: begin
        if (is_io)        st_d = TS_TA;
        else if (!wait_n) st_d = TS_TW;
        else              st_d = TS_T3;
      end
      TS_TA, TS_TW: st_d = wait_n ? TS_T3 : TS_TW;
      TS_T3:   st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  assign done_d = (st_q == TS_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
  // edge that ends the last active state before T3
  assign cap_o   = (st_d == TS_T3) && (st_q != TS_T3);

  // R4
  io_auto_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_T2 && is_io) |=> (st_q == TS_TA));

  // R3 R5
  wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == TS_TA || st_q == TS_TW) && !wait_n) |=> (st_q == TS_TW));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/bcyc_strobe_dec.sv
module bcyc_strobe_dec
  import bcyc_pkg::*;
(
  input  tstate_e state,
  input  ckind_s  kind,
  output logic    mreq_n,
  output logic    iorq_n,
  output logic    rd_n,
  output logic    wr_n,
  output logic    oe
);

  logic active;
  logic middle;

  assign active = (state == TS_T1) || (state == TS_T2) || (state == TS_TA) ||
                  (state == TS_TW) || (state == TS_T3);
  assign middle = (state == TS_T2) || (state == TS_TA) || (state == TS_TW);

  assign mreq_n = !(active && !kind.io);
  assign iorq_n = !(active &&  kind.io);
  assign rd_n   = !(active && !kind.wr);
  assign wr_n   = !(middle &&  kind.wr);
  assign oe     = active && kind.wr;

endmodule

// File: rtl/bcyc_rdata_cap.sv
module bcyc_rdata_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (en) q_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

endmodule

// File: rtl/bcyc_seq.sv
module bcyc_seq
  import bcyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              wait_n,
  input  logic [DATA_W-1:0] din,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              mreq_n,
  output logic              iorq_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic              srst_n;
  tstate_e           state;
  logic              start, cap;
  ckind_s            kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;

  bcyc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign req_ready = (state == TS_IDLE) && !done;
  assign start     = req_valid && req_ready;

  always_comb begin
    kind_d = kind_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (start) begin
      kind_d = ckind_s'(req_kind);
      addr_d = req_addr;
      wdat_d = req_wdata;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      kind_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  bcyc_tstate_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (start),
    .is_io   (kind_q.io),
    .wait_n  (wait_n),
    .state_o (state),
    .cap_o   (cap),
    .done_o  (done)
  );

  bcyc_strobe_dec u_dec (
    .state  (state),
    .kind   (kind_q),
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .oe     (dout_oe)
  );

  bcyc_rdata_cap #(.DATA_W(DATA_W)) u_cap (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (cap && !kind_q.wr),
    .din   (din),
    .q     (rdata)
  );

  assign addr = addr_q;
  assign dout = wdat_q;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(!rd_n && !wr_n));

  // R9
  space_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(!mreq_n && !iorq_n));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state != TS_IDLE && state != TS_T3) |=> $stable(addr));

  // R8
  wr_release_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !wr_n |=> (!wr_n || dout_oe));

  // R10
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    start |=> !req_ready);

endmodule

// File: tb/bcyc_seq_tb.sv
module bcyc_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, done;
  logic [7:0]  rdata;
  logic        wait_n;
  logic [7:0]  din;
  logic [15:0] addr;
  logic [7:0]  dout;
  logic        dout_oe, mreq_n, iorq_n, rd_n, wr_n;

  int vectors = 0;
  int errors  = 0;
  bit summary_done = 0;

  always #5 clk = ~clk;

  bcyc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .wait_n(wait_n), .din(din), .addr(addr),
    .dout(dout), .dout_oe(dout_oe), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
  endtask

  // One machine cycle. nwait: requested waits; t2_glitch: wait_n low in T2 of an I/O cycle.
  task automatic run_cycle(input logic [1:0] kind, input logic [15:0] a, input logic [7:0] wd,
                           input int nwait, input bit t2_glitch, input logic [7:0] rv);
    bit is_io = kind[1];
    bit is_wr = kind[0];
    int exp_done = (is_io ? 5 : 4) + nwait;
    int cap_k    = exp_done - 2;
    int done_k   = 0;
    int sp_cnt = 0, other_cnt = 0, rd_cnt = 0, wr_cnt = 0, both_cnt = 0;
    int addr_bad = 0, data_bad = 0, busy_bad = 0;
    logic last_wr_n = 1'b1, last_oe = 1'b0;

    @(negedge clk);
    chk("R10 ready before request", req_ready, 1);
    req_valid = 1; req_kind = kind; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_addr = ~a; req_wdata = ~wd;
    for (int k = 1; k < 60; k++) begin
      if (is_io) wait_n = !((k >= 3 && k < 3 + nwait) || (t2_glitch && k == 2));
      else       wait_n = !(k >= 2 && k < 2 + nwait);
      din = (k == cap_k) ? rv : ~rv;
      #1;
      if (done) begin done_k = k; break; end
      if (req_ready) busy_bad++;
      if (!(is_io ? iorq_n : mreq_n)) begin
        sp_cnt++;
        if (addr !== a) addr_bad++;
        if (is_wr && (!dout_oe || dout !== wd)) data_bad++;
        last_wr_n = wr_n; last_oe = dout_oe;
      end
      if (!(is_io ? mreq_n : iorq_n)) other_cnt++;
      if (!rd_n) rd_cnt++;
      if (!wr_n) wr_cnt++;
      if (!rd_n && !wr_n) both_cnt++;
      @(negedge clk);
    end
    wait_n = 1;
    chk(is_io ? "R4/R5 done clock" : "R2/R3 done clock", done_k, exp_done);
    chk(is_io ? "R4/R5 strobe clocks" : "R2/R3 strobe clocks", sp_cnt, exp_done - 1);
    chk("R6 wrong space strobe", other_cnt, 0);
    chk("R6 address stable", addr_bad, 0);
    chk("R9 rd and wr together", both_cnt, 0);
    chk("R10 ready low while busy", busy_bad, 0);
    chk("R10 ready low in done clock", req_ready, 0);
    if (is_wr) begin
      chk("R8 data driven", data_bad, 0);
      chk("R8 wr clocks", wr_cnt, exp_done - 3);
      chk("R8 wr high in T3", last_wr_n, 1);
      chk("R8 oe in T3", last_oe, 1);
      chk("R7 no rd in write", rd_cnt, 0);
    end else begin
      chk("R7 rd clocks", rd_cnt, exp_done - 1);
      chk("R7 no wr in read", wr_cnt, 0);
      chk("R7 rdata", rdata, rv);
    end
    @(negedge clk);
    #1;
    chk("R10 done single clock", done, 0);
    chk("R10 ready after done", req_ready, 1);
  endtask

  task automatic test_reset();
    #1;
    chk("R1 mreq_n", mreq_n, 1);
    chk("R1 iorq_n", iorq_n, 1);
    chk("R1 rd_n", rd_n, 1);
    chk("R1 wr_n", wr_n, 1);
    chk("R1 dout_oe", dout_oe, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic test_mem();
    run_cycle(2'b00, 16'h1234, 8'h00, 0, 0, 8'hA5); // R2 read
    run_cycle(2'b01, 16'hBEEF, 8'h3C, 0, 0, 8'h00); // R2 write
    run_cycle(2'b00, 16'h8001, 8'h00, 3, 0, 8'h5A); // R3 read
    run_cycle(2'b01, 16'h7FFE, 8'hC3, 2, 0, 8'h00); // R3 write
  endtask

  task automatic test_io();
    run_cycle(2'b10, 16'h00FE, 8'h00, 0, 0, 8'h96); // R4 read
    run_cycle(2'b11, 16'h00F0, 8'h81, 0, 0, 8'h00); // R4 write
    run_cycle(2'b10, 16'h0042, 8'h00, 0, 1, 8'h69); // R4 wait in T2 ignored
    run_cycle(2'b10, 16'h0010, 8'h00, 2, 0, 8'h0F); // R5 read
    run_cycle(2'b11, 16'hFFFF, 8'h7E, 4, 1, 8'h00); // R5 write
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("WATCHDOG", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_wdata = 0;
    wait_n = 1; din = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    test_reset();
    test_mem();
    test_io();
    summary();
    $finish;
  end

endmodule